// File: doc/BRIEF.md
# Quadrature ROM-less Direct Digital Synthesizer

This block produces a pair of digital sinusoids, a sine (Q) and a cosine (I), whose frequency is set by a tuning word. A phase accumulator advances by the tuning word on every enabled clock and wraps at its width. The phase-to-amplitude stage holds no lookup table. It folds the phase into the first quadrant using the top two phase bits, then approximates the quarter sine with eight straight-line segments. Each segment is evaluated with a small set of right shifts and adders. The sign bit restores the lower half-cycle.

Both channels share one accumulator. The cosine channel reads the same phase advanced by a quarter turn, so the two outputs are always exactly 90 degrees apart. The tuning word is sampled on every enabled cycle. A frequency hop therefore shows on the very next sample, with no settling period. A valid strobe follows the enable through a fixed three-stage pipeline.

Top module: `ddfs_iq`

## Requirements
- R1: Each cycle with `en_i` high takes one sample. The sample's phase is the accumulator value at that moment. The accumulator then adds `ftw_i` modulo 2^PHASE_W. A phase value p stands for the angle 2*pi*p/2^PHASE_W.
- R2: A new `ftw_i` value applies to the phase of the very next sample, with no extra delay or settling period.
- R3: `q_o` is a 10-bit two's complement value within 8 LSB of 511*sin(angle of the sample phase).
- R4: `i_o` is a 10-bit two's complement value within 8 LSB of 511*cos(angle of the sample phase).
- R5: `i_o` at phase p equals exactly `q_o` at phase p + 2^(PHASE_W-2), taken modulo 2^PHASE_W.
- R6: `q_o` at phase p + 2^(PHASE_W-1) equals exactly the negative of `q_o` at phase p. This is the half-cycle sign symmetry.
- R7: The outputs stay within -511..+511, and -512 never appears. `q_o` is exactly 0, +511, 0 and -511 at the phases for 0, 90, 180 and 270 degrees.
- R8: `valid_o` is high exactly three clock edges after an edge that sampled `en_i` high. While `valid_o` is low, `i_o` and `q_o` hold their last values.
- R9: Synchronous reset clears the accumulator to phase 0, drives `valid_o` low and both outputs to 0. The first sample after reset gives `q_o` = 0 and `i_o` = +511.
- R10: A cycle with `en_i` low does not advance the phase. The next enabled sample continues from where the accumulator stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Take a sample and advance the phase this cycle |
| ftw_i | input | PHASE_W | Frequency tuning word, phase step per sample |
| valid_o | output | 1 | `i_o`/`q_o` carry a new sample |
| i_o | output | 10 | Cosine sample, signed |
| q_o | output | 10 | Sine sample, signed |

## Verification
The assertions check four behaviours on every cycle: the three-cycle alignment of `valid_o` with the enable, the hold of the outputs between samples, the exclusion of the -512 code, and the peak pairing. The peak pairing means that a full-scale value on one channel coincides with zero on the other. Approximation accuracy, the exact quadrature and half-cycle symmetries, the reset values and phase continuity across hops and enable gaps need whole sequences of samples. The bench shows these by sweeping every phase value and by driving a pseudo-random hopping pattern. It compares each sample with a real-valued sine and cosine of a phase it tracks on its own.

// File: rtl/ddfs_pkg.sv
package ddfs_pkg;
    localparam int AMP_W   = 10;
    localparam int AMP_MAX = 2 ** (AMP_W - 1) - 1;
    localparam int SEG_W   = 3;

    // intercept of each segment, amplitude units at full scale 511
    function automatic int seg_base(input logic [SEG_W-1:0] seg);
        case (seg)
            3'd0:    return 0;
            3'd1:    return 100;
            3'd2:    return 192;
            3'd3:    return 283;
            3'd4:    return 361;
            3'd5:    return 425;
            3'd6:    return 471;
            default: return 502;
        endcase
    endfunction

    // first slope term: rise over one segment is 2**w
    function automatic int seg_w1(input logic [SEG_W-1:0] seg);
        case (seg)
            3'd0, 3'd1, 3'd2, 3'd3, 3'd4: return 6;
            3'd5, 3'd6:                   return 5;
            default:                      return 3;
        endcase
    endfunction

    // second slope term, negative when absent
    function automatic int seg_w2(input logic [SEG_W-1:0] seg);
        case (seg)
            3'd0, 3'd1, 3'd2: return 5;
            3'd3, 3'd5:       return 4;
            default:          return -1;
        endcase
    endfunction
endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
    parameter int PHASE_W = 13
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [PHASE_W-1:0] ftw,
    output logic [PHASE_W-1:0] phase,
    output logic               valid
);
    typedef struct packed {
        logic [PHASE_W-1:0] acc;
        logic [PHASE_W-1:0] ph;
        logic               v;
    } acc_st_t;

    acc_st_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        s_d.v = en;
        if (en) begin
            s_d.ph  = s_q.acc;
            s_d.acc = s_q.acc + ftw;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign phase = s_q.ph;
    assign valid = s_q.v;
endmodule

// File: rtl/dds_fold.sv
module dds_fold
    import ddfs_pkg::*;
#(
    parameter int PHASE_W = 13,
    localparam int QW     = PHASE_W - 2,
    localparam int OFF_W  = QW - SEG_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ld,
    input  logic [PHASE_W-1:0] phase,
    output logic [SEG_W-1:0]   seg,
    output logic [OFF_W-1:0]   off,
    output logic               neg,
    output logic               full
);
    typedef struct packed {
        logic [SEG_W-1:0] seg;
        logic [OFF_W-1:0] off;
        logic             neg;
        logic             full;
    } fold_st_t;

    fold_st_t s_d, s_q;
    logic [1:0]  quad;
    logic [QW:0] x;

    always_comb begin
        quad = phase[PHASE_W-1 -: 2];
        if (quad[0]) x = (QW+1)'(2 ** QW) - {1'b0, phase[QW-1:0]};
        else         x = {1'b0, phase[QW-1:0]};
        s_d = s_q;
        if (ld) begin
            s_d.full = x[QW];
            s_d.seg  = x[QW-1 -: SEG_W];
            s_d.off  = x[OFF_W-1:0];
            s_d.neg  = quad[1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign seg  = s_q.seg;
    assign off  = s_q.off;
    assign neg  = s_q.neg;
    assign full = s_q.full;
endmodule

// File: rtl/dds_pwl.sv
module dds_pwl
    import ddfs_pkg::*;
#(
    parameter int PHASE_W = 13,
    localparam int OFF_W  = PHASE_W - 2 - SEG_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ld,
    input  logic [SEG_W-1:0]        seg,
    input  logic [OFF_W-1:0]        off,
    input  logic                    neg,
    input  logic                    full,
    output logic signed [AMP_W-1:0] amp
);
    logic signed [AMP_W-1:0] amp_d, amp_q;
    int mag, w1, w2;

    always_comb begin
        w1  = seg_w1(seg);
        w2  = seg_w2(seg);
        mag = seg_base(seg) + (int'(off) >> (OFF_W - w1));
        if (w2 >= 0) mag = mag + (int'(off) >> (OFF_W - w2));
        if (full || mag > AMP_MAX) mag = AMP_MAX;
        amp_d = amp_q;
        if (ld) amp_d = AMP_W'(neg ? -mag : mag);
    end

    always_ff @(posedge clk) begin
        if (rst) amp_q <= '0;
        else     amp_q <= amp_d;
    end

    assign amp = amp_q;
endmodule

// File: rtl/ddfs_iq.sv
module ddfs_iq
    import ddfs_pkg::*;
#(
    parameter int PHASE_W = 13
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en_i,
    input  logic [PHASE_W-1:0]      ftw_i,
    output logic                    valid_o,
    output logic signed [AMP_W-1:0] i_o,
    output logic signed [AMP_W-1:0] q_o
);
    localparam int OFF_W = PHASE_W - 2 - SEG_W;
    localparam logic [PHASE_W-1:0] QUARTER = PHASE_W'(2 ** (PHASE_W - 2));

    typedef struct packed {
        logic s2;
        logic s3;
    } vld_t;

    vld_t v_d, v_q;
    logic [PHASE_W-1:0] ph1;
    logic               v1;
    logic [PHASE_W-1:0] ch_ph [2];
    logic signed [AMP_W-1:0] ch_amp [2];

    dds_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
        .clk(clk), .rst(rst), .en(en_i), .ftw(ftw_i), .phase(ph1), .valid(v1)
    );

    always_comb begin
        ch_ph[0] = ph1;            // sine channel
        ch_ph[1] = ph1 + QUARTER;  // cosine channel, quarter turn ahead
        v_d.s2 = v1;
        v_d.s3 = v_q.s2;
    end

    always_ff @(posedge clk) begin
        if (rst) v_q <= '0;
        else     v_q <= v_d;
    end

    for (genvar ch = 0; ch < 2; ch++) begin : g_ch
        logic [SEG_W-1:0] seg;
        logic [OFF_W-1:0] off;
        logic             neg, full;

        dds_fold #(.PHASE_W(PHASE_W)) u_fold (
            .clk(clk), .rst(rst), .ld(v1), .phase(ch_ph[ch]),
            .seg(seg), .off(off), .neg(neg), .full(full)
        );

        dds_pwl #(.PHASE_W(PHASE_W)) u_pwl (
            .clk(clk), .rst(rst), .ld(v_q.s2), .seg(seg), .off(off),
            .neg(neg), .full(full), .amp(ch_amp[ch])
        );
    end

    assign valid_o = v_q.s3;
    assign q_o     = ch_amp[0];
    assign i_o     = ch_amp[1];
endmodule

// File: rtl/ddfs_iq_chk.sv
module ddfs_iq_chk
    import ddfs_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    en_i,
    input logic                    valid_o,
    input logic signed [AMP_W-1:0] i_o,
    input logic signed [AMP_W-1:0] q_o
);
    localparam logic signed [AMP_W-1:0] NEG_FULL = {1'b1, {(AMP_W-1){1'b0}}};
    localparam logic signed [AMP_W-1:0] PEAK     = AMP_W'(AMP_MAX);

    logic [1:0] cnt;
    always_ff @(posedge clk) begin
        if (rst)            cnt <= 2'd0;
        else if (cnt != 2'd3) cnt <= cnt + 2'd1;
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (cnt == 2'd3) |-> (valid_o == $past(en_i, 3))); // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (cnt != 2'd0 && !valid_o) |-> ($stable(i_o) && $stable(q_o))); // R8
    AST_NO_NEG_FULL: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (i_o != NEG_FULL && q_o != NEG_FULL)); // R7
    AST_SINE_PEAK: assert property (@(posedge clk) disable iff (rst)
        (valid_o && (q_o == PEAK || q_o == -PEAK)) |-> (i_o == 0)); // R5
    AST_COS_PEAK: assert property (@(posedge clk) disable iff (rst)
        (valid_o && i_o == PEAK) |-> (q_o == 0)); // R5
endmodule

bind ddfs_iq ddfs_iq_chk u_chk (.*);

// File: tb/sim_ddfs_iq.sv
module sim_ddfs_iq;
    localparam int PW   = 13;
    localparam int NPH  = 2 ** PW;
    localparam int QTR  = NPH / 4;
    localparam int WD   = 150000;
    localparam real TOL = 8.0;
    localparam real PI  = 3.14159265358979;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en_i = 1'b0;
    logic [PW-1:0] ftw_i = '0;
    logic valid_o;
    logic signed [9:0] i_o, q_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ph_m = 0;
    int ph_fifo[$];
    int ia [NPH];
    int qa [NPH];
    string tag = "reset";

    always #5 clk = ~clk;

    ddfs_iq #(.PHASE_W(PW)) u0 (
        .clk(clk), .rst(rst), .en_i(en_i), .ftw_i(ftw_i),
        .valid_o(valid_o), .i_o(i_o), .q_o(q_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rnd(input real r);
        return $rtoi(r >= 0.0 ? r + 0.5 : r - 0.5);
    endfunction

    task automatic drive(input bit e, input int f);
        @(negedge clk);
        en_i  = e;
        ftw_i = PW'(f);
        if (e) begin
            ph_fifo.push_back(ph_m);
            ph_m = (ph_m + f) % NPH;
        end
    endtask

    // sample monitor, away from the rising edge
    always @(negedge clk) begin
        cyc++;
        if (cyc > WD) begin
            chk(1'b0, "watchdog", cyc, WD);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
        if (!rst && valid_o) begin
            if (ph_fifo.size() == 0) begin
                chk(1'b0, "R8 valid without enable", 1, 0);
            end else begin
                int p;
                real ang, es, ec;
                p   = ph_fifo.pop_front();
                ang = 2.0 * PI * real'(p) / real'(NPH);
                es  = 511.0 * $sin(ang);
                ec  = 511.0 * $cos(ang);
                chk((real'(q_o) - es <= TOL) && (es - real'(q_o) <= TOL),
                    {"R3 sine ", tag}, int'(q_o), rnd(es));
                chk((real'(i_o) - ec <= TOL) && (ec - real'(i_o) <= TOL),
                    {"R4 cosine ", tag}, int'(i_o), rnd(ec));
                qa[p] = int'(q_o);
                ia[p] = int'(i_o);
            end
        end
    end

    initial begin
        logic [15:0] lf;
        int mx, mn;
        lf = 16'hACE1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R9: reset state
        chk(valid_o == 1'b0, "R9 valid after reset", int'(valid_o), 0);
        chk(q_o == 0, "R9 q after reset", int'(q_o), 0);
        chk(i_o == 0, "R9 i after reset", int'(i_o), 0);

        // R8/R9: single sample, latency and hold
        tag = "R8 single";
        drive(1'b1, 0);
        for (int n = 1; n <= 6; n++) begin
            drive(1'b0, 0);
            chk(valid_o == (n == 3), "R8 valid timing", int'(valid_o), int'(n == 3));
            if (n >= 3) begin
                chk(q_o == 0, "R9 first q / R8 hold", int'(q_o), 0);
                chk(i_o == 511, "R9 first i / R8 hold", int'(i_o), 511);
            end
        end

        // full phase sweep, step 1
        tag = "sweep";
        for (int k = 0; k < NPH; k++) drive(1'b1, 1);
        repeat (5) drive(1'b0, 0);
        mx = -1000;
        mn = 1000;
        for (int p = 0; p < NPH; p++) begin
            chk(ia[p] == qa[(p + QTR) % NPH], "R5 quadrature", ia[p], qa[(p + QTR) % NPH]);
            chk(qa[(p + 2 * QTR) % NPH] == -qa[p], "R6 half-cycle sign",
                qa[(p + 2 * QTR) % NPH], -qa[p]);
            if (qa[p] > mx) mx = qa[p];
            if (qa[p] < mn) mn = qa[p];
            if (ia[p] > mx) mx = ia[p];
            if (ia[p] < mn) mn = ia[p];
        end
        chk(qa[0] == 0, "R7 q at 0 deg", qa[0], 0);
        chk(qa[QTR] == 511, "R7 q at 90 deg", qa[QTR], 511);
        chk(qa[2 * QTR] == 0, "R7 q at 180 deg", qa[2 * QTR], 0);
        chk(qa[3 * QTR] == -511, "R7 q at 270 deg", qa[3 * QTR], -511);
        chk(mx == 511, "R7 max code", mx, 511);
        chk(mn == -511, "R7 min code", mn, -511);

        // hopping with enable gaps
        tag = "hop R1 R2 R10";
        for (int k = 0; k < 3000; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            drive(lf[15:14] != 2'b00, int'(lf[12:0]));
        end
        // directed hop: step a quarter turn, then an eighth
        tag = "directed R2";
        drive(1'b1, QTR);
        drive(1'b1, QTR);
        drive(1'b0, 5);
        drive(1'b1, QTR / 2);
        drive(1'b1, QTR / 2);
        repeat (6) drive(1'b0, 0);
        chk(ph_fifo.size() == 0, "R8 every enable produced a sample", ph_fifo.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule